// File: doc/BRIEF.md
# Debug Watchpoint Countdown Unit

This unit holds two 16-bit down-counters that let a debugger stop the processor only after a chosen watchpoint has matched a given number of times. Each counter is bound through a configuration field to one strobe from the instruction-watchpoint group or one strobe from the load/store-watchpoint group. Every qualifying match decrements the counter. When the count runs out, the unit sends a single-cycle breakpoint request of the matching kind: an instruction request or a load/store request.

The two kinds handle the last match in different ways. A load/store match stands for an access that has already completed, so the counter drops to zero and the handler reads zero. An instruction match is taken before the instruction executes. Its decrement is held as pending until the instruction retires, and it is dropped if the instruction is flushed. At a count of one, the request fires in place of the decrement, so the handler reads one. A masked mode makes both counters ignore matches while the recoverable-interrupt status is clear.

Each request is gated by an effective trap enable. That enable is the OR of a software bit, which only supervisor code may change, and a bit supplied by the debug port. Software reaches the counters, the configuration and the enables through a small registered read/write port.

Top module: `dbg_wp_countdown`

## Requirements
- R1: After reset both counters read 0. Writing address 0 or 1 loads counter 0 or counter 1 with the full 16-bit write data, and that value reads back at the same address.
- R2: Address 2 holds the configuration. For counter k, bits [4k+2:4k] select the strobe index and bit 4k+3 selects the group (0 = instruction strobes `iwp_hit`, 1 = load/store strobes `lwp_hit`). An index beyond the selected group's width, or a strobe that is not selected, has no effect. The register reads back as written.
- R3: While `mask_en` is 1 and `ri_flag` is 0, watchpoint strobes do not change any counter and raise no request.
- R4: In load/store mode, a qualifying strobe on a nonzero counter decrements it in the same cycle. When the strobe takes the counter from 1 to 0, `brk_ls[k]` is high for exactly the cycle after the sampling edge, and the counter then reads 0.
- R5: In instruction mode, a qualifying strobe on a counter above 1 leaves the readable value unchanged and marks a pending decrement. `retire` commits it (the value drops by one), and `flush` without `retire` discards it. Strobes that arrive while a decrement is pending are ignored.
- R6: In instruction mode, a qualifying strobe on an armed counter at 1 raises `brk_instr[k]` for the cycle after the sampling edge and leaves the counter at 1. The counter is then disarmed, and further strobes neither change it nor raise a request until it is written again.
- R7: A counter at 0 is never decremented, does not wrap, and raises no request on further strobes.
- R8: A counter write in the same cycle as a qualifying strobe wins: the written value is loaded, any pending decrement is dropped, and the counter is re-armed.
- R9: At address 3, bits [1:0] are the software trap enables. They are written only when `supervisor` is 1, and a write with `supervisor` 0 leaves them unchanged. A read returns the software bits in [1:0] and `dp_te` in [9:8]. A request for counter k is sent only if software bit k or `dp_te[k]` is 1.
- R10: A read with `reg_re` presents the addressed register on `reg_rdata` in the cycle after the edge, and `reg_rdata` holds its value while `reg_re` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iwp_hit | input | N_IWP | Instruction-watchpoint match strobes |
| lwp_hit | input | N_LWP | Load/store-watchpoint match strobes (access completed) |
| retire | input | 1 | The instruction that holds a pending decrement has retired |
| flush | input | 1 | The instruction that holds a pending decrement was aborted |
| ri_flag | input | 1 | Recoverable-interrupt status |
| mask_en | input | 1 | Masked mode: ignore strobes while ri_flag is 0 |
| supervisor | input | 1 | Processor is in supervisor state |
| dp_te | input | 2 | Trap enables supplied by the debug port |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | CNT_W | Register write data |
| reg_rdata | output | CNT_W | Registered read data |
| brk_instr | output | 2 | Instruction breakpoint request per counter |
| brk_ls | output | 2 | Load/store breakpoint request per counter |

## Verification
Counter 0 runs in load/store mode and counter 1 in instruction mode. Strobes go to the selected index, to an unselected index, and with the mask active and inactive, which separates strobe selection from qualification. Instruction strobes are followed by retire, by flush, or by another strobe while a decrement is pending, so a wrong commit or rollback shows up as an off-by-one readback. The end-of-count runs compare the handler's view (0 for load/store, 1 for instruction), re-fire after disarm and after reload, a write colliding with a strobe, and the two enable sources alone, so each gating path is seen on its own.

// File: rtl/dbg_wp_pkg.sv
package dbg_wp_pkg;
  localparam int NUM_CNT = 2;
  localparam int SEL_W   = 3;

  typedef struct packed {
    logic             is_ls;
    logic [SEL_W-1:0] sel;
  } wp_cfg_t;

  localparam int CFG_W = $bits(wp_cfg_t);

  typedef enum logic [1:0] {
    RA_CNT0 = 2'd0,
    RA_CNT1 = 2'd1,
    RA_CFG  = 2'd2,
    RA_TRAP = 2'd3
  } reg_addr_e;

  localparam int DP_RD_LSB = 8;
endpackage

// File: rtl/wp_evt_qual.sv
module wp_evt_qual
  import dbg_wp_pkg::*;
#(
  parameter int N_IWP = 4,
  parameter int N_LWP = 2
) (
  input  wp_cfg_t           cfg,
  input  logic [N_IWP-1:0]  iwp_hit,
  input  logic [N_LWP-1:0]  lwp_hit,
  input  logic              mask_en,
  input  logic              ri_flag,
  output logic              evt
);
  logic i_sel, l_sel, blocked;

  always_comb begin
    i_sel = 1'b0;
    for (int k = 0; k < N_IWP; k++)
      if (cfg.sel == SEL_W'(k)) i_sel = i_sel | iwp_hit[k];
  end

  always_comb begin
    l_sel = 1'b0;
    for (int k = 0; k < N_LWP; k++)
      if (cfg.sel == SEL_W'(k)) l_sel = l_sel | lwp_hit[k];
  end

  assign blocked = mask_en & ~ri_flag;
  assign evt     = (cfg.is_ls ? l_sel : i_sel) & ~blocked;
endmodule

// File: rtl/wp_counter.sv
module wp_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             is_ls,
  input  logic             evt,
  input  logic             retire,
  input  logic             flush,
  output logic [CNT_W-1:0] cnt,
  output logic             fire_instr,
  output logic             fire_ls
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic pend;
  logic armed;

  always_comb begin
    fire_ls    = is_ls & evt & ~wr_en & (cnt == ONE);
    fire_instr = ~is_ls & evt & ~wr_en & ~pend & armed & (cnt == ONE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      pend  <= 1'b0;
      armed <= 1'b0;
    end else if (wr_en) begin
      cnt   <= wr_data;
      pend  <= 1'b0;
      armed <= 1'b1;
    end else if (is_ls) begin
      pend <= 1'b0;
      if (evt && cnt != '0) cnt <= cnt - ONE;
    end else if (pend) begin
      if (retire) begin
        cnt  <= cnt - ONE;
        pend <= 1'b0;
      end else if (flush) begin
        pend <= 1'b0;
      end
    end else if (evt && cnt > ONE) begin
      pend <= 1'b1;
    end else if (fire_instr) begin
      armed <= 1'b0;
    end
  end

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> cnt == $past(wr_data)); // R8
  AST_ZERO_STAYS: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && cnt == '0) |=> cnt == '0); // R7
  AST_LS_STEP: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && is_ls && evt && cnt != '0) |=> cnt == $past(cnt) - ONE); // R4
  AST_INSTR_HELD: assert property (@(posedge clk) disable iff (rst)
    fire_instr |=> cnt == ONE); // R6
  AST_NO_REFIRE: assert property (@(posedge clk) disable iff (rst)
    fire_instr |=> !fire_instr); // R6
  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (rst)
    (pend && !retire && !wr_en && !is_ls) |=> cnt == $past(cnt)); // R5
endmodule

// File: rtl/wp_trap_gate.sv
module wp_trap_gate #(
  parameter int NUM = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           sw_we,
  input  logic           supervisor,
  input  logic [NUM-1:0] sw_wdata,
  input  logic [NUM-1:0] dp_te,
  input  logic [NUM-1:0] fire_instr,
  input  logic [NUM-1:0] fire_ls,
  output logic [NUM-1:0] sw_te,
  output logic [NUM-1:0] brk_instr,
  output logic [NUM-1:0] brk_ls
);
  logic [NUM-1:0] te_eff;
  assign te_eff = sw_te | dp_te;

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_te     <= '0;
      brk_instr <= '0;
      brk_ls    <= '0;
    end else begin
      if (sw_we && supervisor) sw_te <= sw_wdata;
      brk_instr <= fire_instr & te_eff;
      brk_ls    <= fire_ls & te_eff;
    end
  end

  AST_USER_LOCK: assert property (@(posedge clk) disable iff (rst)
    (sw_we && !supervisor) |=> sw_te == $past(sw_te)); // R9
  AST_GATED_REQ: assert property (@(posedge clk) disable iff (rst)
    ##1 ((brk_instr | brk_ls) & ~$past(sw_te | dp_te)) == '0); // R9
endmodule

// File: rtl/dbg_wp_countdown.sv
module dbg_wp_countdown
  import dbg_wp_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int N_IWP = 4,
  parameter int N_LWP = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_IWP-1:0] iwp_hit,
  input  logic [N_LWP-1:0] lwp_hit,
  input  logic             retire,
  input  logic             flush,
  input  logic             ri_flag,
  input  logic             mask_en,
  input  logic             supervisor,
  input  logic [1:0]       dp_te,
  input  logic             reg_we,
  input  logic             reg_re,
  input  logic [1:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  output logic [1:0]       brk_instr,
  output logic [1:0]       brk_ls
);
  localparam int CFG_BITS = NUM_CNT * CFG_W;

  wp_cfg_t [NUM_CNT-1:0] cfg_q;
  logic [CNT_W-1:0]      cnt   [NUM_CNT];
  logic [NUM_CNT-1:0]    cnt_we, evt, f_instr, f_ls;
  logic [NUM_CNT-1:0]    sw_te;
  logic                  cfg_we, trap_we;
  logic [CNT_W-1:0]      rd_mux;

  assign cfg_we  = reg_we && (reg_addr == RA_CFG);
  assign trap_we = reg_we && (reg_addr == RA_TRAP);

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= '0;
    else if (cfg_we) cfg_q <= reg_wdata[CFG_BITS-1:0];
  end

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    assign cnt_we[i] = reg_we && (reg_addr == 2'(i));

    wp_evt_qual #(.N_IWP(N_IWP), .N_LWP(N_LWP)) u_qual (
      .cfg(cfg_q[i]), .iwp_hit(iwp_hit), .lwp_hit(lwp_hit),
      .mask_en(mask_en), .ri_flag(ri_flag), .evt(evt[i])
    );

    wp_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst(rst), .wr_en(cnt_we[i]), .wr_data(reg_wdata),
      .is_ls(cfg_q[i].is_ls), .evt(evt[i]), .retire(retire), .flush(flush),
      .cnt(cnt[i]), .fire_instr(f_instr[i]), .fire_ls(f_ls[i])
    );

    AST_MASKED_IDLE: assert property (@(posedge clk) disable iff (rst)
      (mask_en && !ri_flag && !cnt_we[i] && !retire) |=> $stable(cnt[i])); // R3
  end

  wp_trap_gate #(.NUM(NUM_CNT)) u_gate (
    .clk(clk), .rst(rst), .sw_we(trap_we), .supervisor(supervisor),
    .sw_wdata(reg_wdata[NUM_CNT-1:0]), .dp_te(dp_te),
    .fire_instr(f_instr), .fire_ls(f_ls),
    .sw_te(sw_te), .brk_instr(brk_instr), .brk_ls(brk_ls)
  );

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      RA_CNT0: rd_mux = cnt[0];
      RA_CNT1: rd_mux = cnt[1];
      RA_CFG:  rd_mux[CFG_BITS-1:0] = cfg_q;
      default: begin
        rd_mux[NUM_CNT-1:0]             = sw_te;
        rd_mux[DP_RD_LSB +: NUM_CNT]    = dp_te;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (reg_re) reg_rdata <= rd_mux;
  end

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !reg_re |=> $stable(reg_rdata)); // R10
endmodule

// File: tb/sim_dbg_wp_countdown.sv
`timescale 1ns/1ps
module sim_dbg_wp_countdown;
  localparam int CNT_W = 16;
  localparam int N_IWP = 4;
  localparam int N_LWP = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N_IWP-1:0] iwp_hit = '0;
  logic [N_LWP-1:0] lwp_hit = '0;
  logic retire = 0, flush = 0, ri_flag = 1, mask_en = 0, supervisor = 1;
  logic [1:0] dp_te = '0;
  logic reg_we = 0, reg_re = 0;
  logic [1:0] reg_addr = '0;
  logic [CNT_W-1:0] reg_wdata = '0;
  logic [CNT_W-1:0] reg_rdata;
  logic [1:0] brk_instr, brk_ls;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dbg_wp_countdown #(.CNT_W(CNT_W), .N_IWP(N_IWP), .N_LWP(N_LWP)) u0 (
    .clk(clk), .rst(rst), .iwp_hit(iwp_hit), .lwp_hit(lwp_hit),
    .retire(retire), .flush(flush), .ri_flag(ri_flag), .mask_en(mask_en),
    .supervisor(supervisor), .dp_te(dp_te), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .brk_instr(brk_instr), .brk_ls(brk_ls)
  );

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output int d);
    reg_re = 1; reg_addr = a;
    @(negedge clk);
    reg_re = 0;
    d = int'(reg_rdata);
  endtask

  task automatic ev_ls(input int idx);
    lwp_hit[idx] = 1'b1;
    @(negedge clk);
    lwp_hit = '0;
  endtask

  task automatic ev_i(input int idx);
    iwp_hit[idx] = 1'b1;
    @(negedge clk);
    iwp_hit = '0;
  endtask

  task automatic t_reset();
    int d;
    check("R1 reset brk_instr", int'(brk_instr), 0);
    check("R1 reset brk_ls", int'(brk_ls), 0);
    rd(2'd0, d); check("R1 reset cnt0", d, 0);
    rd(2'd1, d); check("R1 reset cnt1", d, 0);
  endtask

  task automatic t_regs();
    int d;
    wr(2'd0, 16'd5);      rd(2'd0, d); check("R1 cnt0 readback", d, 5);
    wr(2'd1, 16'hBEEF);   rd(2'd1, d); check("R1 cnt1 readback", d, 16'hBEEF);
    // counter 0: load/store, index 1; counter 1: instruction, index 2
    wr(2'd2, 16'h0029);   rd(2'd2, d); check("R2 cfg readback", d, 16'h0029);
    @(negedge clk);
    check("R10 rdata holds", int'(reg_rdata), 16'h0029);
    wr(2'd3, 16'h0003);   rd(2'd3, d); check("R9 trap readback", d, 3);
  endtask

  task automatic t_ls();
    int d;
    wr(2'd0, 16'd2);
    ev_ls(1); check("R4 no early brk", int'(brk_ls), 0);
    rd(2'd0, d); check("R4 step to 1", d, 1);
    ev_ls(0); rd(2'd0, d); check("R2 unselected strobe", d, 1);
    ev_i(1);  rd(2'd0, d); check("R2 wrong group", d, 1);
    ev_ls(1); check("R4 brk_ls pulse", int'(brk_ls), 1);
    check("R4 no instr brk", int'(brk_instr), 0);
    @(negedge clk); check("R4 pulse single", int'(brk_ls), 0);
    rd(2'd0, d); check("R4 handler sees 0", d, 0);
    ev_ls(1); check("R7 no brk at zero", int'(brk_ls), 0);
    rd(2'd0, d); check("R7 no wrap", d, 0);
  endtask

  task automatic t_mask();
    int d;
    wr(2'd0, 16'd3);
    mask_en = 1; ri_flag = 0;
    ev_ls(1); rd(2'd0, d); check("R3 masked ignored", d, 3);
    ri_flag = 1;
    ev_ls(1); rd(2'd0, d); check("R3 counted with ri", d, 2);
    mask_en = 0; ri_flag = 0;
    ev_ls(1); rd(2'd0, d); check("R3 unmasked counts", d, 1);
    ri_flag = 1;
  endtask

  task automatic t_instr();
    int d;
    wr(2'd1, 16'd3);
    ev_i(2); rd(2'd1, d); check("R5 pending invisible", d, 3);
    ev_i(2); rd(2'd1, d); check("R5 strobe while pending", d, 3);
    retire = 1; @(negedge clk); retire = 0;
    rd(2'd1, d); check("R5 commit on retire", d, 2);
    ev_i(2);
    flush = 1; @(negedge clk); flush = 0;
    rd(2'd1, d); check("R5 rollback on flush", d, 2);
    ev_i(2);
    retire = 1; @(negedge clk); retire = 0;
    rd(2'd1, d); check("R5 commit to 1", d, 1);
    ev_i(2); check("R6 brk_instr pulse", int'(brk_instr), 2);
    check("R6 no ls brk", int'(brk_ls), 0);
    rd(2'd1, d); check("R6 handler sees 1", d, 1);
    ev_i(2); check("R6 disarmed no brk", int'(brk_instr), 0);
    retire = 1; @(negedge clk); retire = 0;
    rd(2'd1, d); check("R6 disarmed count held", d, 1);
    wr(2'd1, 16'd1);
    ev_i(2); check("R6 rearm by write", int'(brk_instr), 2);
  endtask

  task automatic t_collide();
    int d;
    wr(2'd0, 16'd1);
    reg_we = 1; reg_addr = 2'd0; reg_wdata = 16'd7; lwp_hit[1] = 1'b1;
    @(negedge clk);
    reg_we = 0; lwp_hit = '0;
    check("R8 no brk on collide", int'(brk_ls), 0);
    rd(2'd0, d); check("R8 write wins", d, 7);
  endtask

  task automatic t_trap();
    int d;
    supervisor = 0; wr(2'd3, 16'h0000); supervisor = 1;
    rd(2'd3, d); check("R9 user write blocked", d, 3);
    wr(2'd3, 16'h0000);
    wr(2'd0, 16'd1);
    ev_ls(1); check("R9 disabled no brk", int'(brk_ls), 0);
    rd(2'd0, d); check("R9 count still reaches 0", d, 0);
    dp_te = 2'b01;
    wr(2'd0, 16'd1);
    ev_ls(1); check("R9 dp enable brk", int'(brk_ls), 1);
    rd(2'd3, d); check("R9 read dp bits", d, 16'h0100);
    dp_te = 2'b00;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_ls();
    t_mask();
    t_instr();
    t_collide();
    t_trap();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule